// File: doc/BRIEF.md
# Pause-Width Bit Encoder

This block sends a reader-to-card frame on a single line that idles high. Each bit opens with a short low pause. The line then returns high, and the total length of the bit carries its value: a long bit is a one and a short bit is a zero. All timing is counted in ticks of an external tick enable, nominally 1.5 MHz, so one tick is two thirds of a microsecond. After the last bit, a trailing low pause closes the frame.

A controller presents a frame word of up to 32 bits and a bit count, then pulses `start`. The encoder keeps `busy` high while the frame is on the line and pulses `done` when the line has returned high. Before each bit goes out, the encoder XORs it with a keystream bit supplied from outside. It pulses `ks_adv` once per bit so that the keystream source can step to its next bit.

A guard interval of high line is enforced before the first pause. This interval is measured from the end of the previous frame, or from the release of reset. Idle time already spent counts toward the guard. Every pause and bit deadline is added to one running timestamp, so per-phase delays cannot accumulate into drift.

Top module: `pwb_tx`

## Requirements
- R1: After reset and whenever the block is idle, `line_out` is 1 and `busy`, `done` and `ks_adv` are 0.
- R2: A `start` pulse while idle with a nonzero `frame_len` is accepted at that clock edge, and `busy` stays 1 until the frame's `done` pulse.
- R3: Between the end of one frame (or reset release) and the first pause of the next, the line stays high for at least GUARD_T ticks (330). Idle ticks count toward this guard, so a start that comes after at least GUARD_T idle ticks drives the line low at the accepting clock edge.
- R4: Every transmitted bit begins with a low pause of exactly PAUSE_T ticks (30).
- R5: An on-air 1 lasts ONE_T ticks (150) and an on-air 0 lasts ZERO_T ticks (90), both measured from the start of the bit's pause to the start of the next pause.
- R6: Frame bits are sent from bit 0 of `frame_word` upward, and exactly as many bits are sent as the effective length.
- R7: The on-air bit is the frame bit XOR `ks_bit`, sampled in the last cycle of that bit's pause. `ks_adv` is a one-cycle pulse after each bit, giving exactly one pulse per bit.
- R8: After the last bit, a trailing low pause of PAUSE_T ticks is sent. The line then returns high, and `done` pulses for one cycle in the first cycle the line is high again.
- R9: A `start` pulse while `busy` is 1 is ignored: the running frame continues unchanged and no second frame follows.
- R10: A `start` with `frame_len` 0 produces a `done` pulse in the next cycle, with no pause, no `ks_adv` and no `busy`.
- R11: A `frame_len` above 32 is treated as 32.
- R12: All durations count `tick_en` pulses, not clock cycles. With one tick every three clocks, each duration is three times as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timing tick enable, one cycle per tick |
| start | input | 1 | Begin a frame (ignored while busy) |
| frame_word | input | 32 | Frame bits, bit 0 sent first |
| frame_len | input | 6 | Number of bits to send (0 to 32, larger clamps to 32) |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle pulse: step the keystream |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame completion |
| line_out | output | 1 | Encoded line, idles high |

## Verification
The bench measures every pause width and every fall-to-fall interval in clock cycles. From these it decodes the received bits and compares them against the frame word XORed with its own model of the keystream. A design that sampled the keystream one step late, or that sent the most significant bit first, would decode to the wrong value. Back-to-back frames check that the high interval before the next pause is exactly the guard, while a long idle gap must give an immediate pause. A meter that charged the guard from `start`, or double-counted the start cycle, would be off by the idle time or by one cycle. The remaining corner cases are a zero length (which must not emit a stray tail pause), a length of 40 (which must clamp to 32), a `start` pulse in mid-frame (which must not restart or append a frame), and a one-in-three tick rate (which shows up any counter that runs on clocks instead of ticks).

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_PAUSE,
        ST_MARK,
        ST_TAIL
    } pwb_state_e;

endpackage

// File: rtl/pwb_gap_meter.sv
// Counts idle ticks since the end of the last frame, saturating at the guard.
module pwb_gap_meter #(
    parameter int GUARD_T = 330,
    localparam int GAP_W  = $clog2(GUARD_T + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_en,
    input  logic             clear,
    output logic [GAP_W-1:0] gap_room
);

    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (clear) begin
            gap_d = '0;
        end else if (count_en && tick && (gap_q < GAP_W'(GUARD_T))) begin
            gap_d = gap_q + 1'b1;
        end
        gap_room = GAP_W'(GUARD_T) - gap_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    a_r3_gap_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(GUARD_T));

    a_r3_gap_holds_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(gap_q));

endmodule

// File: rtl/pwb_deadline.sv
// Running tick timestamp with an accumulating deadline.
module pwb_deadline #(
    parameter int TS_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            active,
    input  logic            restart,
    input  logic            extend,
    input  logic [TS_W-1:0] amt,
    output logic            expire
);

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic [TS_W-1:0] due;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d   = tm_q;
        expire = active && tick && ((tm_q.ts + 1'b1) == tm_q.due);
        if (restart) begin
            tm_d.ts  = '0;
            tm_d.due = amt;
        end else begin
            if (active && tick) tm_d.ts = tm_q.ts + 1'b1;
            if (extend)         tm_d.due = tm_q.due + amt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    a_r12_ts_behind_due: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (tm_q.ts < tm_q.due));

    a_r12_ts_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !restart) |=> $stable(tm_q.ts));

endmodule

// File: rtl/pwb_tx.sv
module pwb_tx #(
    parameter int WORD_W  = 32,
    parameter int GUARD_T = 330,
    parameter int PAUSE_T = 30,
    parameter int ONE_T   = 150,
    parameter int ZERO_T  = 90,
    localparam int LEN_W  = $clog2(WORD_W + 1),
    localparam int TS_W   = $clog2(GUARD_T + WORD_W * ONE_T + PAUSE_T + 1),
    localparam int GAP_W  = $clog2(GUARD_T + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              start,
    input  logic [WORD_W-1:0] frame_word,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              ks_bit,
    output logic              ks_adv,
    output logic              busy,
    output logic              done,
    output logic              line_out
);
    import pwb_pkg::*;

    typedef struct packed {
        pwb_state_e        state;
        logic [WORD_W-1:0] shreg;
        logic [LEN_W-1:0]  left;
        logic              adv;
        logic              done;
    } tx_t;

    tx_t r_d, r_q;

    logic             expire;
    logic             restart;
    logic             extend;
    logic [TS_W-1:0]  amt;
    logic             gap_clear;
    logic [GAP_W-1:0] gap_room;
    logic [LEN_W-1:0] eff_len;
    logic             air;

    pwb_gap_meter #(.GUARD_T(GUARD_T)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .count_en (!busy),
        .clear    (gap_clear),
        .gap_room (gap_room)
    );

    pwb_deadline #(.TS_W(TS_W)) u_dl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .active  (busy),
        .restart (restart),
        .extend  (extend),
        .amt     (amt),
        .expire  (expire)
    );

    always_comb begin
        r_d       = r_q;
        r_d.adv   = 1'b0;
        r_d.done  = 1'b0;
        restart   = 1'b0;
        extend    = 1'b0;
        amt       = '0;
        gap_clear = 1'b0;
        eff_len   = (frame_len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : frame_len;
        air       = r_q.shreg[0] ^ ks_bit;

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (eff_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.shreg = frame_word;
                        r_d.left  = eff_len;
                        restart   = 1'b1;
                        if (gap_room == '0) begin
                            r_d.state = ST_PAUSE;
                            amt       = TS_W'(PAUSE_T);
                        end else begin
                            r_d.state = ST_GUARD;
                            amt       = TS_W'(gap_room);
                        end
                    end
                end
            end
            ST_GUARD: begin
                if (expire) begin
                    r_d.state = ST_PAUSE;
                    extend    = 1'b1;
                    amt       = TS_W'(PAUSE_T);
                end
            end
            ST_PAUSE: begin
                if (expire) begin
                    r_d.state = ST_MARK;
                    extend    = 1'b1;
                    amt       = air ? TS_W'(ONE_T - PAUSE_T) : TS_W'(ZERO_T - PAUSE_T);
                end
            end
            ST_MARK: begin
                if (expire) begin
                    r_d.adv   = 1'b1;
                    r_d.shreg = r_q.shreg >> 1;
                    r_d.left  = r_q.left - 1'b1;
                    extend    = 1'b1;
                    amt       = TS_W'(PAUSE_T);
                    r_d.state = (r_q.left == LEN_W'(1)) ? ST_TAIL : ST_PAUSE;
                end
            end
            ST_TAIL: begin
                if (expire) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    gap_clear = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.shreg <= '0;
            r_q.left  <= '0;
            r_q.adv   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign line_out = !((r_q.state == ST_PAUSE) || (r_q.state == ST_TAIL));
    assign ks_adv   = r_q.adv;
    assign done     = r_q.done;

    // Checker state: ticks spent with the line low in the current pause.
    logic [TS_W-1:0] low_ticks_q;
    always_ff @(posedge clk) begin
        if (!rst_n || line_out) low_ticks_q <= '0;
        else if (tick_en)       low_ticks_q <= low_ticks_q + 1'b1;
    end

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (line_out && !ks_adv));

    a_r4_pause_bound: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks_q <= TS_W'(PAUSE_T));

    a_r7_adv_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |-> (r_q.state == ST_PAUSE || r_q.state == ST_TAIL));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && r_q.state != ST_MARK) |=> $stable(r_q.left));

endmodule

// File: tb/pwb_tx_test.sv
module pwb_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int GUARD_T = 330;
    localparam int PAUSE_T = 30;
    localparam int ONE_T   = 150;
    localparam int ZERO_T  = 90;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        start;
    logic [31:0] frame_word;
    logic [5:0]  frame_len;
    logic        ks_bit;
    logic        ks_adv;
    logic        busy;
    logic        done;
    logic        line_out;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwb_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .start      (start),
        .frame_word (frame_word),
        .frame_len  (frame_len),
        .ks_bit     (ks_bit),
        .ks_adv     (ks_adv),
        .busy       (busy),
        .done       (done),
        .line_out   (line_out)
    );

    // Tick source: one tick every tick_per clocks.
    int tick_per = 1;
    int tdiv = 0;
    always @(posedge clk) tdiv <= (tdiv >= tick_per - 1) ? 0 : tdiv + 1;
    assign tick_en = (tdiv == 0);

    // Keystream source owned by the bench.
    function automatic logic [7:0] ks_nx(input logic [7:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
    endfunction

    logic [7:0] ks_q;
    always @(posedge clk) begin
        if (!rst_n)      ks_q <= 8'hB7;
        else if (ks_adv) ks_q <= ks_nx(ks_q);
    end
    assign ks_bit = ks_q[0];

    // Line monitor.
    int cyc = 0;
    int fall_t[48];
    int rise_t[48];
    int nfall = 0, nrise = 0, nadv = 0, ndone = 0, nbusy = 0;
    int last_rise = 0;
    logic prev_line = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (line_out !== prev_line) begin
            if (!line_out) begin
                if (nfall < 48) fall_t[nfall] = cyc;
                nfall++;
            end else begin
                if (nrise < 48) rise_t[nrise] = cyc;
                nrise++;
                last_rise = cyc;
            end
        end
        prev_line = line_out;
        if (ks_adv) nadv++;
        if (done)   ndone++;
        if (busy)   nbusy++;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        nfall = 0; nrise = 0; nadv = 0; ndone = 0; nbusy = 0;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    // Sends one frame and checks its waveform; returns the measured guard.
    task automatic run_frame(input logic [31:0] w, input int l, input int expn,
                             input int inject_at, input bit imm_low,
                             input string tag, output int guard_meas);
        int prev_rise;
        int steps;
        logic [7:0] s;
        logic [31:0] exp_air;
        logic [31:0] rx;
        int bad_low, bad_per;
        prev_rise = last_rise;
        clear_mon();
        s = ks_q;
        frame_word = w;
        frame_len = 6'(l);
        start = 1'b1;
        step();
        start = 1'b0;
        if (imm_low)
            chk(line_out == 1'b0 && busy == 1'b1, "R3", {tag, " pause at accept edge"},
                line_out, 0);
        steps = 0;
        while (ndone == 0) begin
            if (steps == inject_at) begin
                frame_word = ~w;
                frame_len = 6'd3;
                start = 1'b1;
                step();
                start = 1'b0;
                frame_word = w;
                frame_len = 6'(l);
            end else begin
                step();
            end
            steps++;
        end
        step();
        step();

        exp_air = '0;
        for (int i = 0; i < expn; i++) begin
            exp_air[i] = w[i] ^ s[0];
            s = ks_nx(s);
        end

        chk(nfall == expn + 1, "R6", {tag, " pause count"}, nfall, expn + 1);
        chk(nadv == expn, "R7", {tag, " keystream steps"}, nadv, expn);
        chk(ndone == 1, "R8", {tag, " done pulses"}, ndone, 1);

        bad_low = 0;
        bad_per = 0;
        rx = '0;
        for (int i = 0; i <= expn && i < 47; i++) begin
            if (rise_t[i] - fall_t[i] != PAUSE_T * tick_per) bad_low++;
        end
        for (int i = 0; i < expn && i < 47; i++) begin
            int d;
            d = fall_t[i + 1] - fall_t[i];
            if (d == ONE_T * tick_per) rx[i] = 1'b1;
            if (d != (exp_air[i] ? ONE_T : ZERO_T) * tick_per) bad_per++;
        end
        chk(bad_low == 0, "R4", {tag, " pause widths off"}, bad_low, 0);
        chk(bad_per == 0, "R5", {tag, " bit durations off"}, bad_per, 0);
        chk(rx == exp_air, "R7", {tag, " decoded bits"}, rx, exp_air);
        chk(expn < 48 && rise_t[expn] - fall_t[expn] == PAUSE_T * tick_per && line_out == 1'b1,
            "R8", {tag, " trailing pause"}, rise_t[expn] - fall_t[expn], PAUSE_T * tick_per);
        chk(nbusy > 0 && busy == 1'b0, "R2", {tag, " busy span"}, busy, 0);
        guard_meas = fall_t[0] - prev_rise;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        start = 1'b0;
        frame_word = '0;
        frame_len = '0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk(line_out == 1'b1, "R1", "line after reset", line_out, 1);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(ks_adv == 1'b0, "R1", "ks_adv after reset", ks_adv, 0);
    endtask

    task automatic t_basic();
        int g;
        tick_per = 1;
        run_frame(32'h0000_00A5, 8, 8, -1, 1'b0, "basic", g);
        run_frame(32'h0000_007F, 7, 7, -1, 1'b0, "ones", g);
        run_frame(32'h0000_0000, 6, 6, -1, 1'b0, "zeros", g);
    endtask

    task automatic t_guard();
        int g;
        tick_per = 1;
        run_frame(32'h0000_0013, 5, 5, -1, 1'b0, "guardA", g);
        run_frame(32'h0000_002C, 6, 6, -1, 1'b0, "guardB", g);
        chk(g == GUARD_T, "R3", "back-to-back guard cycles", g, GUARD_T);
        repeat (400) step();
        run_frame(32'h0000_0155, 9, 9, -1, 1'b1, "longidle", g);
        chk(g > GUARD_T, "R3", "long idle high time", g, GUARD_T + 1);
    endtask

    task automatic t_len_zero();
        clear_mon();
        frame_word = 32'hFFFF_FFFF;
        frame_len = 6'd0;
        start = 1'b1;
        step();
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R10", "zero length done", done, 1);
        repeat (20) step();
        chk(nfall == 0 && nadv == 0 && nbusy == 0, "R10", "zero length activity",
            nfall + nadv + nbusy, 0);
        chk(ndone == 1, "R10", "zero length done pulses", ndone, 1);
    endtask

    task automatic t_len_over();
        int g;
        tick_per = 1;
        run_frame(32'hC3A5_0F96, 40, 32, -1, 1'b0, "R11 clamp", g);
        run_frame(32'h8000_0001, 32, 32, -1, 1'b0, "R6 full", g);
    endtask

    task automatic t_busy_start();
        int g;
        tick_per = 1;
        run_frame(32'h0000_0029, 6, 6, 450, 1'b0, "R9 start in frame", g);
        repeat (400) step();
        chk(nfall == 7 && busy == 1'b0, "R9", "no second frame", nfall, 7);
    endtask

    task automatic t_slow_tick();
        int g;
        tick_per = 3;
        repeat (3) step();
        run_frame(32'h0000_001D, 5, 5, -1, 1'b0, "R12 slow tick", g);
        tick_per = 1;
        repeat (3) step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_guard();
        t_len_zero();
        t_len_over();
        t_busy_start();
        t_slow_tick();
        summary();
        $finish;
    end

endmodule